// File: doc/BRIEF.md
# I2C Target Register Control Port

This block is an I2C target that gives an external bus controller read and write access to a bank of 8-bit control registers. The whole bank is also presented as one flat parallel output, so the rest of the chip sees every register value at all times. The block works from a fast system clock. SCL and SDA arrive already synchronised to that clock, and the block finds the bus edges and the START and STOP conditions by comparing each sample with the one before it. The target has no chip-select. A transaction reaches it only when the 7-bit device address matches: a fixed upper nibble of binary 1001, followed by three strap inputs.

A write sends the address byte and then a pointer byte. Bit 7 of the pointer byte is an auto-increment flag, and bits 3:0 are a register index. Any further bytes are data for the selected register. A read starts returning the selected register straight after the address acknowledge. With auto-increment clear, every transfer uses the same register. With it set, the index steps forward after each byte, so a controller can move a block of consecutive registers in one transaction. A repeated START keeps the pointer, so a pointer write followed by a repeated START and a read is the usual way to read a chosen register.

Top module: `i2c_regport`

## Requirements
- R1: An address byte whose bits 7:4 are 1001 and whose bits 3:1 equal strap_i[2:0] (strap_i[2] in bit 3) is acknowledged. The block pulls SDA low through the whole ninth SCL clock. Address bit 0 is the direction: 1 for read, 0 for write.
- R2: After an address byte that does not match, the block never pulls SDA low and writes no register until the next START.
- R3: In a write, the byte after the address is the pointer. Each later byte is stored in the register the pointer selects, and each received byte is acknowledged.
- R4: In the pointer byte, bit 7 is the auto-increment flag and bits 3:0 are the register index. Bits 6:4 have no effect.
- R5: Reset clears every register to 0x00, the index to 0 and the auto-increment flag to 0.
- R6: With auto-increment clear, the index stays the same across successive data bytes, in both reads and writes.
- R7: With auto-increment set, the index advances by one after each byte is written, and wraps from 15 to 0.
- R8: In a read, the register at the current index is shifted out MSB first, starting right after the address acknowledge.
- R9: With auto-increment set, the index advances after each byte read. After a byte it sends, the block releases SDA in the ninth clock. If that clock carries a NACK, the block stays released until the next START.
- R10: A START in the middle of a transaction (repeated START) returns the block to address reception and keeps the pointer.
- R11: A STOP returns the block to idle with SDA released. The pointer is retained, and SCL clocks without a START get no acknowledge.
- R12: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| strap_i | input | 3 | Low three device-address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| regs_o | output | 128 | All registers, register k in bits 8k+7:8k |

## Verification
Some rules are checked by assertions on every cycle:
- the SDA drive changes only while SCL is low;
- the drive is off in the controller's acknowledge slot and while a non-matching transaction is being ignored;
- a STOP leads to idle;
- the index holds while auto-increment is clear and no pointer is being loaded;
- every register write lands at its address.

Other behaviour needs whole transactions to observe, so only the bench scenarios can show it:
- that the address compare uses the straps;
- that the reserved pointer bits have no effect;
- that the index wraps from 15 to 0;
- read data order and the increment during reads;
- that the pointer survives a repeated START and a STOP.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } port_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_regport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl = scl_i;
        smp_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{scl: 1'b1, sda: 1'b1};
        else        smp_q <= smp_d;
    end

    always_comb begin
        evt_o.scl_rise = scl_i & ~smp_q.scl;
        evt_o.scl_fall = ~scl_i & smp_q.scl;
        evt_o.start    = scl_i & smp_q.scl & smp_q.sda & ~sda_i;
        evt_o.stop     = scl_i & smp_q.scl & ~smp_q.sda & sda_i;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               waddr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [IDX_W-1:0]               raddr_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic [(DATA_W<<IDX_W)-1:0]     regs_o
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    always_comb begin
        for (int k = 0; k < NREG; k++) mem_d[k] = mem_q[k];
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) mem_q[k] <= '0;
        end else begin
            for (int k = 0; k < NREG; k++) mem_q[k] <= mem_d[k];
        end
    end

    assign rdata_o = mem_q[raddr_i];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_o[$past(waddr_i)*DATA_W +: DATA_W] == $past(wdata_i)));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         IDX_W  = 4,
    parameter int         DATA_W = 8,
    parameter logic [3:0] DEV_HI = 4'b1001
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    input  logic [2:0]                  strap_i,
    output logic                        sda_oe_o,
    output logic [(DATA_W<<IDX_W)-1:0]  regs_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        port_state_e       st;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] tx;
        logic [IDX_W-1:0]  idx;
        logic              incr;
        logic              rw;
        logic              nack;
        logic              oe;
    } ctl_t;

    ctl_t r_d, r_q;
    bus_evt_t evt;
    logic we;
    logic ptr_load;
    logic [DATA_W-1:0] rdata;

    i2c_bus_events u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_reg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (r_q.idx),
        .wdata_i (r_q.sh),
        .raddr_i (r_q.idx),
        .rdata_o (rdata),
        .regs_o  (regs_o)
    );

    always_comb begin
        r_d      = r_q;
        we       = 1'b0;
        ptr_load = 1'b0;
        if (evt.stop) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (evt.start) begin
            r_d.st     = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (evt.scl_rise && r_q.bitcnt != LAST) begin
                        r_d.sh     = {r_q.sh[DATA_W-2:0], sda_i};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (evt.scl_fall && r_q.bitcnt == LAST) begin
                        r_d.oe = 1'b1;
                        if (r_q.st == ST_ADDR) begin
                            if (r_q.sh[7:1] == {DEV_HI, strap_i}) begin
                                r_d.rw = r_q.sh[0];
                                r_d.st = ST_ADDR_ACK;
                            end else begin
                                r_d.oe = 1'b0;
                                r_d.st = ST_IGNORE;
                            end
                        end else if (r_q.st == ST_PTR) begin
                            ptr_load = 1'b1;
                            r_d.idx  = r_q.sh[IDX_W-1:0];
                            r_d.incr = r_q.sh[DATA_W-1];
                            r_d.st   = ST_PTR_ACK;
                        end else begin
                            we = 1'b1;
                            if (r_q.incr) r_d.idx = r_q.idx + 1'b1;
                            r_d.st = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.tx = rdata;
                            r_d.oe = ~rdata[DATA_W-1];
                            r_d.st = ST_RDATA;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        r_d.oe     = 1'b0;
                        r_d.bitcnt = '0;
                        r_d.st     = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (evt.scl_fall && r_q.bitcnt == LAST) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_RD_ACK;
                        if (r_q.incr) r_d.idx = r_q.idx + 1'b1;
                    end else if (evt.scl_fall && r_q.bitcnt != '0) begin
                        r_d.tx = {r_q.tx[DATA_W-2:0], 1'b0};
                        r_d.oe = ~r_q.tx[DATA_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) begin
                        r_d.nack = sda_i;
                    end else if (evt.scl_fall) begin
                        if (r_q.nack) begin
                            r_d.st = ST_IGNORE;
                        end else begin
                            r_d.tx     = rdata;
                            r_d.oe     = ~rdata[DATA_W-1];
                            r_d.bitcnt = '0;
                            r_d.st     = ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe_o = r_q.oe;

    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.oe != $past(r_q.oe)) |-> !scl_i);
    p_ack_slot_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD_ACK) |-> !sda_oe_o);
    p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IGNORE) |-> (!sda_oe_o && !we));
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (r_q.st == ST_IDLE && !sda_oe_o));
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !r_q.incr) |=> $stable(r_q.idx));
endmodule

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic [127:0] regs;
    wire sda_bus = sda_drv & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int hi_changes = 0;
    logic [7:0] model [16];
    logic [3:0] m_idx = '0;
    logic m_incr = 1'b0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    i2c_regport dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
    );

    always @(negedge clk) begin
        if (rst_n && scl && sda_oe != prev_oe) hi_changes++;
        prev_oe <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [3:0] hi, input logic [2:0] st, input logic rd);
        return {hi, st, rd};
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; waitn(5); scl = 1'b1; waitn(5);
        sda_drv = 1'b0; waitn(5); scl = 1'b0; waitn(5);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; waitn(5); scl = 1'b1; waitn(5);
        sda_drv = 1'b1; waitn(10);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_drv = b; waitn(5); scl = 1'b1; waitn(5);
        s = sda_bus; waitn(5); scl = 1'b0; waitn(5);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b, output logic oe_after);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~ack_it, s);
        sda_drv = 1'b1;
        oe_after = sda_oe;
    endtask

    task automatic check_regs(input string tag);
        logic ok = 1'b1;
        for (int k = 0; k < 16; k++) if (regs[k*8 +: 8] !== model[k]) ok = 1'b0;
        check(ok, tag, 32'(regs[31:0]), {model[3], model[2], model[1], model[0]});
    endtask

    task automatic do_write(input logic [3:0] idx, input logic inc, input logic [2:0] rsv, input int n);
        logic a;
        bus_start();
        send_byte(addr_byte(4'b1001, strap, 1'b0), a);
        check(a, "R1 address ack (write)", 32'(a), 1);
        send_byte({inc, rsv, idx}, a);
        check(a, "R3 pointer ack", 32'(a), 1);
        m_idx = idx; m_incr = inc;
        for (int j = 0; j < n; j++) begin
            logic [7:0] d = 8'($urandom);
            send_byte(d, a);
            check(a, "R3 data ack", 32'(a), 1);
            model[m_idx] = d;
            if (m_incr) m_idx = m_idx + 1'b1;
        end
        bus_stop();
        check_regs(inc ? "R7 registers after auto-increment write" : "R6 registers after fixed-index write");
    endtask

    task automatic do_read(input bit set_ptr, input logic [3:0] idx, input logic inc, input int n, input string tag);
        logic a, oe_after;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            send_byte(addr_byte(4'b1001, strap, 1'b0), a);
            send_byte({inc, 3'b000, idx}, a);
            m_idx = idx; m_incr = inc;
            bus_start();
        end
        send_byte(addr_byte(4'b1001, strap, 1'b1), a);
        check(a, "R1 address ack (read)", 32'(a), 1);
        for (int j = 0; j < n; j++) begin
            recv_byte(j != n - 1, d, oe_after);
            check(d == model[m_idx], tag, 32'(d), 32'(model[m_idx]));
            if (m_incr) m_idx = m_idx + 1'b1;
        end
        check(!oe_after, "R9 SDA released after NACK", 32'(oe_after), 0);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        logic oe_after;
        void'($urandom(32'd4242));
        waitn(4);
        for (int k = 0; k < 16; k++) model[k] = 8'h00;
        check(regs == '0 && !sda_oe, "R5 reset state", 32'(regs[31:0]), 0);
        rst_n = 1'b1;
        waitn(10);

        // R5/R8: read with no pointer write reads register 0 after reset
        do_read(1'b0, 4'd0, 1'b0, 1, "R8 read after reset");

        // R6: fixed index writes land only in one register
        do_write(4'd3, 1'b0, 3'b000, 3);
        // R7: auto-increment with wrap 15 -> 0
        do_write(4'd14, 1'b1, 3'b000, 4);
        // R4: reserved bits set have no effect
        do_write(4'd6, 1'b1, 3'b111, 2);

        // R8/R9: read block with auto-increment
        do_read(1'b1, 4'd14, 1'b1, 4, "R9 incrementing read data");
        // R6: fixed-index read repeats the same register
        do_read(1'b1, 4'd3, 1'b0, 3, "R6 fixed-index read data");

        // R10: pointer kept across repeated START (pointer then rstart read)
        do_read(1'b1, 4'd6, 1'b0, 1, "R10 read after repeated START");
        // R11: pointer retained across STOP
        do_read(1'b0, 4'd0, 1'b0, 1, "R11 pointer kept after STOP");

        // R2: strap mismatch, no ack, no write
        bus_start();
        send_byte(addr_byte(4'b1001, ~strap, 1'b0), a);
        check(!a, "R2 strap mismatch no ack", 32'(a), 0);
        send_byte(8'h85, a);
        send_byte(8'h5A, a);
        check(!a, "R2 silent after mismatch", 32'(a), 0);
        bus_stop();
        check_regs("R2 no write after mismatch");
        bus_start();
        send_byte(addr_byte(4'b1011, strap, 1'b0), a);
        check(!a, "R2 upper nibble mismatch no ack", 32'(a), 0);
        bus_stop();

        // R11: clocking after STOP without START gets no ack
        send_byte(addr_byte(4'b1001, strap, 1'b0), a);
        check(!a, "R11 no ack without START", 32'(a), 0);
        send_byte(8'h00, a);
        check(!a && !sda_oe, "R11 idle after STOP", 32'(a), 0);
        check_regs("R11 no write without START");

        // R1: a different strap setting moves the address
        strap = 3'b010;
        do_read(1'b0, 4'd0, 1'b0, 1, "R1 read with new strap");

        // random mix
        for (int t = 0; t < 24; t++) begin
            logic [3:0] ri = 4'($urandom);
            logic ru = 1'($urandom);
            if ($urandom_range(0, 2) == 0)
                do_read(1'b1, ri, ru, 1 + $urandom_range(0, 3), ru ? "R9 random read" : "R8 random read");
            else
                do_write(ri, ru, 3'($urandom), 1 + $urandom_range(0, 4));
        end

        // R12: no SDA drive change while SCL high
        check(hi_changes == 0, "R12 SDA changed with SCL high", 32'(hi_changes), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule